// File: doc/BRIEF.md
# Three-channel down-counting timer with watchdog reset

This block holds three down-counters of 32 bits behind a small word-wide register bus. Channel 0 produces a periodic tick event. Channel 1 runs without stopping and serves as a timestamp: software subtracts the value it reads from all-ones to get the elapsed clocks. Channel 2 is a watchdog. Software must rewrite it before it runs out, or it raises its own event and, if allowed, pulls a reset line low for a fixed number of clocks.

Each channel has a count register and a reload register. One shared control word holds an enable bit and an auto-reload bit for each channel. The tick and watchdog events latch into a cause register. A mask register gates the cause bits onto two interrupt lines. A separate enable register decides whether a watchdog expiry reaches the reset line. A cause bit is cleared by writing a 0 to it and is left alone by writing a 1, so a read-modify-write of the cause register clears only the bits software means to clear.

Top module: `tmr_wdog_unit`

## Requirements
- R1: After reset every register reads zero, both interrupt lines are low and `wdog_rst_n` is high.
- R2: Byte addresses: channel i count at 0x00+8*i, channel i reload at 0x04+8*i, control at 0x20, cause at 0x24, mask at 0x28, reset enable at 0x2C. The control bits are bit 2i for channel i enable and bit 2i+1 for channel i auto-reload. Cause and mask use bit 0 for the tick and bit 1 for the watchdog. Reset enable is bit 0. Register bits that are not implemented, and addresses that are not mapped, read as zero.
- R3: An enabled channel whose count is not zero decreases its count by exactly one on every clock.
- R4: An enabled channel with auto-reload set expires on the clock that takes its count from 1 to 0. On the following clock it loads its reload value, so the period is reload+1 clocks. An expiry of channel 0 sets cause bit 0 on the same clock that the count reaches zero.
- R5: An enabled channel with auto-reload clear stays at zero after it expires and sets its cause bit only once.
- R6: A write to the cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: `tick_irq` and `wdog_irq` are each high exactly when both the cause bit and the mask bit of that source are 1.
- R8: Channel 1, with reload 0xFFFFFFFF and auto-reload set, steps from 0 to 0xFFFFFFFF. 0xFFFFFFFF minus the value read back gives the clocks elapsed since the wrap.
- R9: A count-register write sets the count on the next clock and takes the place of that clock's decrement or reload.
- R10: A watchdog expiry sets cause bit 1. It leaves `wdog_rst_n` high while reset enable is 0.
- R11: A watchdog expiry with reset enable 1 drives `wdog_rst_n` low from the same clock edge for exactly RST_PULSE clocks (16 by default).
- R12: A write to the watchdog count register on the clock the watchdog would expire cancels the expiry: no cause bit and no reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_addr | input | ADDR_W (6) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| tick_irq | output | 1 | Tick interrupt, cause bit 0 AND mask bit 0 |
| wdog_irq | output | 1 | Watchdog interrupt, cause bit 1 AND mask bit 1 |
| wdog_rst_n | output | 1 | Registered active-low watchdog reset pulse |

## Verification
The hardest case to reach from the ports is a watchdog rewrite that lands on the exact clock the count would step from 1 to 0. The bench arms the watchdog with a small count and reads the count at each falling edge. It starts the rewrite in the cycle where the read shows 1, so the write is captured on the expiry edge. The reset pulse is checked cycle by cycle for its exact length. The one-shot and wrap cases are reached the same way, by loading small counts and counting clocks from the control write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int NCH      = 3;
   localparam int CH_TICK  = 0;
   localparam int CH_TS    = 1;
   localparam int CH_WD    = 2;

   localparam int NEV      = 2;
   localparam int EV_TICK  = 0;
   localparam int EV_WD    = 1;

   localparam int CNT_BASE   = 'h00;
   localparam int RLD_BASE   = 'h04;
   localparam int CH_STRIDE  = 'h08;
   localparam int CTRL_ADDR  = 'h20;
   localparam int CAUSE_ADDR = 'h24;
   localparam int MASK_ADDR  = 'h28;
   localparam int RSTEN_ADDR = 'h2C;

   function automatic int cnt_addr(input int ch);
      return CNT_BASE + ch * CH_STRIDE;
   endfunction

   function automatic int rld_addr(input int ch);
      return RLD_BASE + ch * CH_STRIDE;
   endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             auto_rld,
   input  logic             cnt_wr,
   input  logic             rld_wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] rld,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // expiry is the 1 -> 0 step; a same-cycle count write suppresses it
   assign expire = en && !cnt_wr && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cnt_wr) begin
         cnt <= wdata;
      end else if (en) begin
         if (cnt != '0)    cnt <= cnt - ONE;
         else if (auto_rld) cnt <= rld;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rld <= '0;
      else if (rld_wr) rld <= wdata;
   end
endmodule

// File: rtl/tmr_evt_regs.sv
module tmr_evt_regs #(
   parameter int NEV = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NEV-1:0] evt,
   input  logic           cause_wr,
   input  logic           mask_wr,
   input  logic           rsten_wr,
   input  logic [NEV-1:0] wbits,
   input  logic           wen_bit,
   output logic [NEV-1:0] cause,
   output logic [NEV-1:0] mask,
   output logic           rst_en,
   output logic [NEV-1:0] irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause  <= '0;
         mask   <= '0;
         rst_en <= 1'b0;
      end else begin
         // write-0-to-clear, new events win over a clear in the same cycle
         cause <= (cause_wr ? (cause & wbits) : cause) | evt;
         if (mask_wr)  mask   <= wbits;
         if (rsten_wr) rst_en <= wen_bit;
      end
   end

   assign irq = cause & mask;
endmodule

// File: rtl/tmr_rst_pulse.sv
module tmr_rst_pulse #(
   parameter int LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic rst_out_n
);
   localparam int CW = $clog2(LEN + 1);
   localparam logic [CW-1:0] LEN_V = CW'(LEN);
   localparam logic [CW-1:0] ONE_V = CW'(1);

   generate
      if (LEN < 2) begin : g_bad_len
         $error("tmr_rst_pulse: LEN must be at least 2");
      end
   endgenerate

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q    <= '0;
         rst_out_n <= 1'b1;
      end else begin
         if (fire)              left_q <= LEN_V;
         else if (left_q != '0) left_q <= left_q - ONE_V;
         rst_out_n <= !(fire || (left_q > ONE_V));
      end
   end
endmodule

// File: rtl/tmr_wdog_unit.sv
module tmr_wdog_unit #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 6,
   parameter int CNT_W     = 32,
   parameter int RST_PULSE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tick_irq,
   output logic              wdog_irq,
   output logic              wdog_rst_n
);
   import tmr_pkg::*;

   localparam int CTRL_W = 2 * NCH;

   generate
      if (CNT_W > DATA_W) begin : g_chk_w
         $error("tmr_wdog_unit: CNT_W must not exceed DATA_W");
      end
      if (ADDR_W < 6) begin : g_chk_a
         $error("tmr_wdog_unit: ADDR_W too small for the register map");
      end
      if (RST_PULSE < 16) begin : g_chk_p
         $error("tmr_wdog_unit: RST_PULSE must be at least 16");
      end
   endgenerate

   logic [CTRL_W-1:0]           ctrl_q;
   logic [NCH-1:0][CNT_W-1:0]   chan_cnt;
   logic [NCH-1:0][CNT_W-1:0]   chan_rld;
   logic [NCH-1:0]              chan_exp;
   logic [NEV-1:0]              evt;
   logic [NEV-1:0]              cause_q;
   logic [NEV-1:0]              mask_q;
   logic [NEV-1:0]              irq_v;
   logic                        rst_en;
   logic                        ctrl_wr, cause_wr, mask_wr, rsten_wr;

   assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign cause_wr = bus_wr && (bus_addr == ADDR_W'(CAUSE_ADDR));
   assign mask_wr  = bus_wr && (bus_addr == ADDR_W'(MASK_ADDR));
   assign rsten_wr = bus_wr && (bus_addr == ADDR_W'(RSTEN_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0];
   end

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_chan
         localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(cnt_addr(g));
         localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(rld_addr(g));
         tmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ctrl_q[2*g]),
            .auto_rld (ctrl_q[2*g+1]),
            .cnt_wr   (bus_wr && (bus_addr == A_CNT)),
            .rld_wr   (bus_wr && (bus_addr == A_RLD)),
            .wdata    (bus_wdata[CNT_W-1:0]),
            .cnt      (chan_cnt[g]),
            .rld      (chan_rld[g]),
            .expire   (chan_exp[g])
         );
      end
   endgenerate

   logic unused_ts_exp;
   assign unused_ts_exp = chan_exp[CH_TS];

   always_comb begin
      evt          = '0;
      evt[EV_TICK] = chan_exp[CH_TICK];
      evt[EV_WD]   = chan_exp[CH_WD];
   end

   tmr_evt_regs #(.NEV(NEV)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .cause_wr (cause_wr),
      .mask_wr  (mask_wr),
      .rsten_wr (rsten_wr),
      .wbits    (bus_wdata[NEV-1:0]),
      .wen_bit  (bus_wdata[0]),
      .cause    (cause_q),
      .mask     (mask_q),
      .rst_en   (rst_en),
      .irq      (irq_v)
   );

   assign tick_irq = irq_v[EV_TICK];
   assign wdog_irq = irq_v[EV_WD];

   tmr_rst_pulse #(.LEN(RST_PULSE)) u_rst (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (chan_exp[CH_WD] && rst_en),
      .rst_out_n (wdog_rst_n)
   );

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == ADDR_W'(cnt_addr(i))) bus_rdata = DATA_W'(chan_cnt[i]);
         if (bus_addr == ADDR_W'(rld_addr(i))) bus_rdata = DATA_W'(chan_rld[i]);
      end
      if (bus_addr == ADDR_W'(CTRL_ADDR))  bus_rdata = DATA_W'(ctrl_q);
      if (bus_addr == ADDR_W'(CAUSE_ADDR)) bus_rdata = DATA_W'(cause_q);
      if (bus_addr == ADDR_W'(MASK_ADDR))  bus_rdata = DATA_W'(mask_q);
      if (bus_addr == ADDR_W'(RSTEN_ADDR)) bus_rdata = DATA_W'(rst_en);
   end
endmodule

// File: rtl/tmr_wdog_chk.sv
module tmr_wdog_chk #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 6,
   parameter int CNT_W     = 32,
   parameter int RST_PULSE = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [CNT_W-1:0]  cnt0,
   input logic [CNT_W-1:0]  cnt2,
   input logic [5:0]        ctrl,
   input logic [1:0]        cause,
   input logic              rst_en,
   input logic              wdog_rst_n
);
   import tmr_pkg::*;

   logic wr_c0, wr_c2, wr_cause;
   assign wr_c0    = bus_wr && (bus_addr == ADDR_W'(cnt_addr(CH_TICK)));
   assign wr_c2    = bus_wr && (bus_addr == ADDR_W'(cnt_addr(CH_WD)));
   assign wr_cause = bus_wr && (bus_addr == ADDR_W'(CAUSE_ADDR));

   logic [15:0] low_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               low_len <= '0;
      else if (!wdog_rst_n)     low_len <= (low_len == 16'hFFFF) ? low_len : low_len + 16'd1;
      else                      low_len <= '0;
   end

   p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[0] && !wr_c0 && cnt0 != '0) |=> (cnt0 == $past(cnt0) - CNT_W'(1)));

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cause && !bus_wdata[0] && !(ctrl[0] && cnt0 == CNT_W'(1))) |=> !cause[0]);

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cause[0] && !wr_cause) |=> cause[0]);

   p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c2 |=> (cnt2 == $past(bus_wdata[CNT_W-1:0])));

   p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdog_rst_n) |-> $past(rst_en));

   p_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdog_rst_n) |-> (low_len >= 16'(RST_PULSE)));

   p_kick_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c2 && !cause[1]) |=> !cause[1]);
endmodule

bind tmr_wdog_unit tmr_wdog_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RST_PULSE(RST_PULSE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .cnt0       (chan_cnt[0]),
   .cnt2       (chan_cnt[2]),
   .ctrl       (ctrl_q),
   .cause      (cause_q),
   .rst_en     (rst_en),
   .wdog_rst_n (wdog_rst_n)
);

// File: tb/tb_tmr_wdog_unit.sv
module tb_tmr_wdog_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_irq, wdog_irq, wdog_rst_n;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tmr_wdog_unit dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq),
      .wdog_irq(wdog_irq), .wdog_rst_n(wdog_rst_n)
   );

   // {addr, write data, expected readback}  -- R2 register map
   localparam int NV = 11;
   localparam logic [69:0] VEC [NV] = '{
      {6'h04, 32'h12345678, 32'h12345678},
      {6'h0C, 32'h89ABCDEF, 32'h89ABCDEF},
      {6'h14, 32'h0F0F0F0F, 32'h0F0F0F0F},
      {6'h00, 32'h00000007, 32'h00000007},
      {6'h08, 32'hDEADBEEF, 32'hDEADBEEF},
      {6'h10, 32'h00000100, 32'h00000100},
      {6'h20, 32'hFFFFFFC0, 32'h00000000},
      {6'h28, 32'hFFFFFFFF, 32'h00000003},
      {6'h2C, 32'hFFFFFFFF, 32'h00000001},
      {6'h30, 32'hFFFFFFFF, 32'h00000000},
      {6'h20, 32'h0000002A, 32'h0000002A}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge: write captured at next rising edge, returns at next falling edge
   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(6'h20, v); check("R1 ctrl", v, 32'h0);
      rd(6'h24, v); check("R1 cause", v, 32'h0);
      rd(6'h00, v); check("R1 count0", v, 32'h0);
      rd(6'h14, v); check("R1 reload2", v, 32'h0);
      check("R1 irq", {30'd0, tick_irq, wdog_irq}, 32'h0);
      check("R1 rst_out", {31'd0, wdog_rst_n}, 32'h1);

      // R2 register table
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][69:64], VEC[i][63:32]);
         rd(VEC[i][69:64], v);
         check("R2 readback", v, VEC[i][31:0]);
      end
      wr(6'h20, 32'h0);
      wr(6'h28, 32'h0);
      wr(6'h2C, 32'h0);

      // R3/R4 channel 0 periodic tick, reload 5
      wr(6'h00, 32'd5);
      wr(6'h04, 32'd5);
      wr(6'h20, 32'h3);
      rd(6'h00, v); check("R4 start count", v, 32'd5);
      repeat (4) @(negedge clk);
      rd(6'h00, v); check("R3 decrement", v, 32'd1);
      rd(6'h24, v); check("R4 cause before expiry", v, 32'h0);
      @(negedge clk);
      rd(6'h00, v); check("R4 at zero", v, 32'd0);
      rd(6'h24, v); check("R4 cause on expiry", v, 32'h1);
      check("R7 masked tick", {31'd0, tick_irq}, 32'h0);
      @(negedge clk);
      rd(6'h00, v); check("R4 reload", v, 32'd5);
      wr(6'h28, 32'h1);
      check("R7 unmasked tick", {31'd0, tick_irq}, 32'h1);
      wr(6'h20, 32'h0);
      wr(6'h24, 32'h3);
      rd(6'h24, v); check("R6 write one keeps", v, 32'h1);
      wr(6'h24, 32'h2);
      rd(6'h24, v); check("R6 write zero clears", v, 32'h0);
      check("R7 tick drops", {31'd0, tick_irq}, 32'h0);

      // R5 one-shot
      wr(6'h00, 32'd3);
      wr(6'h20, 32'h1);
      repeat (3) @(negedge clk);
      rd(6'h24, v); check("R5 expiry", v, 32'h1);
      wr(6'h24, 32'h0);
      repeat (5) @(negedge clk);
      rd(6'h00, v); check("R5 stays zero", v, 32'd0);
      rd(6'h24, v); check("R5 no second event", v, 32'h0);
      wr(6'h20, 32'h0);
      wr(6'h28, 32'h0);

      // R8 free-running channel 1
      wr(6'h0C, 32'hFFFFFFFF);
      wr(6'h08, 32'd3);
      wr(6'h20, 32'hC);
      repeat (3) @(negedge clk);
      rd(6'h08, v); check("R8 reaches zero", v, 32'd0);
      @(negedge clk);
      rd(6'h08, v); check("R8 wrap", v, 32'hFFFFFFFF);
      repeat (7) @(negedge clk);
      rd(6'h08, v2); check("R8 elapsed", 32'hFFFFFFFF - v2, 32'd7);
      wr(6'h08, 32'd100);
      rd(6'h08, v); check("R9 write beats decrement", v, 32'd100);
      @(negedge clk);
      rd(6'h08, v); check("R3 after write", v, 32'd99);
      wr(6'h20, 32'h0);

      // R10 watchdog expiry with reset gated off
      wr(6'h10, 32'd2);
      wr(6'h20, 32'h10);
      repeat (2) @(negedge clk);
      rd(6'h24, v); check("R10 cause", v, 32'h2);
      check("R10 no reset", {31'd0, wdog_rst_n}, 32'h1);
      wr(6'h28, 32'h2);
      check("R7 wdog irq", {31'd0, wdog_irq}, 32'h1);
      repeat (3) @(negedge clk);
      check("R10 still no reset", {31'd0, wdog_rst_n}, 32'h1);
      wr(6'h24, 32'h1);
      check("R7 wdog irq clears", {31'd0, wdog_irq}, 32'h0);
      wr(6'h20, 32'h0);

      // R12 kick on the expiry edge, then R11 pulse length
      wr(6'h2C, 32'h1);
      wr(6'h10, 32'd4);
      wr(6'h20, 32'h10);
      repeat (3) @(negedge clk);
      rd(6'h10, v); check("R12 count at one", v, 32'd1);
      wr(6'h10, 32'd10);
      rd(6'h10, v); check("R12 kick loaded", v, 32'd10);
      rd(6'h24, v); check("R12 no cause", v, 32'h0);
      check("R12 no reset", {31'd0, wdog_rst_n}, 32'h1);
      repeat (10) @(negedge clk);
      rd(6'h24, v); check("R11 expiry cause", v, 32'h2);
      begin
         int lows = 0;
         for (int k = 0; k < 16; k++) begin
            if (!wdog_rst_n) lows++;
            @(negedge clk);
         end
         check("R11 low cycles", lows, 32'd16);
      end
      check("R11 released", {31'd0, wdog_rst_n}, 32'h1);

      finish_run();
   end
endmodule